// File: doc/BRIEF.md
# Signed Carry-Save Array Multiplier

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit signed product. It uses a rectangular array of full-adder rows. Each row takes one partial-product vector from AND gates and folds it into a running pair of vectors, one for sums and one for carries. No carry travels along a row. The carry vector is always moved one column up, because a carry weighs twice as much as a sum bit in its own column.

Signs are handled inside the array by the modified Baugh-Wooley method. In each row the partial-product bits that pair a sign bit with a magnitude bit are inverted. The one bit that pairs the two sign bits is left as it is. Two constant ones, at columns N and 2N-1, are loaded into the sum vector before the first row. No partial product is sign-extended. A single ripple carry-propagate adder below the array merges the last sum and carry vectors. An optional register, with a synchronous active-high reset, holds the product.

Top module: `bw_csa_mult`

## Requirements
- R1: With the output register enabled, `prod_out` one clock after an edge equals the signed product of `a_in` and `b_in` sampled at that edge, as a 2N-bit two's-complement value. The most significant bit of each operand has weight -2^(N-1).
- R2: When `rst` is high at a clock edge, `prod_out` becomes zero after that edge, whatever the operand values.
- R3: The most negative operand times itself gives +2^(2N-2), with bit 2N-1 clear. For N=16 this is 0x40000000.
- R4: The most negative operand times -1 gives +2^(N-1), in either operand order. For N=16 this is 0x00008000.
- R5: After each array row, the sum vector plus the carry vector (mod 2^2N) equals that row's incoming pair plus the row's partial-product vector.
- R6: A zero operand gives a zero product. This holds even though the constant ones are always injected.
- R7: Products whose operands have opposite signs are negative. Products of two negative operands are positive. Both follow the two's-complement encoding of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | N | Multiplicand, two's complement |
| b_in | input | N | Multiplier, two's complement |
| prod_out | output | 2N | Signed product, two's complement |

## Verification
The hardest case to reach is the one where the injected constant ones must be cancelled exactly by the inverted sign-pair terms. This happens when the sign bits are set and the magnitudes are extreme. It covers the most negative operand paired with itself, with -1 and with the largest positive value. Random operands almost never produce these cases. The bench therefore holds them in a fixed vector table for the 16-bit instance. It also runs every operand pair of a 4-bit instance, and then drives a long run of random 16-bit operands.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  // Full-adder sum and carry used by every array cell and the final adder.
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // Modified Baugh-Wooley correction: constant ones at columns n and 2n-1.
  function automatic logic corr_bit(input int n, input int col);
    return (col == n) || (col == 2 * n - 1);
  endfunction
endpackage

// File: rtl/bwm_pp_row.sv
module bwm_pp_row #(
  parameter int N   = 16,
  parameter int ROW = 0
) (
  input  logic [N-1:0]   mcand,
  input  logic           mplier_bit,
  output logic [2*N-1:0] pp_vec
);
  localparam int W = 2 * N;

  for (genvar k = 0; k < W; k++) begin : g_col
    if (k >= ROW && k < ROW + N) begin : g_live
      localparam int I = k - ROW;
      // Cells pairing exactly one sign bit take the inverted term.
      if ((I == N - 1) != (ROW == N - 1)) begin : g_inv
        assign pp_vec[k] = ~(mcand[I] & mplier_bit);
      end else begin : g_plain
        assign pp_vec[k] = mcand[I] & mplier_bit;
      end
    end else begin : g_zero
      assign pp_vec[k] = 1'b0;
    end
  end
endmodule

// File: rtl/bwm_csa_row.sv
module bwm_csa_row #(
  parameter int W = 32
) (
  input  logic [W-1:0] sum_in,
  input  logic [W-1:0] cry_in,
  input  logic [W-1:0] pp_in,
  output logic [W-1:0] sum_out,
  output logic [W-1:0] cry_out
);
  import bwm_pkg::*;

  assign cry_out[0] = 1'b0;
  for (genvar k = 0; k < W; k++) begin : g_fa
    assign sum_out[k] = fa_sum(sum_in[k], cry_in[k], pp_in[k]);
    // Carry leaves one column higher; the top carry falls off (mod 2^W).
    if (k < W - 1) begin : g_up
      assign cry_out[k+1] = fa_carry(sum_in[k], cry_in[k], pp_in[k]);
    end
  end
endmodule

// File: rtl/bwm_cpa.sv
module bwm_cpa #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  output logic [W-1:0] total
);
  import bwm_pkg::*;

  logic [W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar k = 0; k < W; k++) begin : g_rip
    assign total[k]   = fa_sum(op_x[k], op_y[k], chain[k]);
    assign chain[k+1] = fa_carry(op_x[k], op_y[k], chain[k]);
  end
endmodule

// File: rtl/bw_csa_mult.sv
module bw_csa_mult #(
  parameter int N       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [N-1:0]   a_in,
  input  logic signed [N-1:0]   b_in,
  output logic signed [2*N-1:0] prod_out
);
  import bwm_pkg::*;

  localparam int W = 2 * N;

  logic [W-1:0] sum_v [0:N];
  logic [W-1:0] cry_v [0:N];
  logic [W-1:0] pp_v  [0:N-1];
  logic [W-1:0] prod_c;

  // Seed the sum vector with the precomputed constant ones.
  for (genvar k = 0; k < W; k++) begin : g_seed
    assign sum_v[0][k] = corr_bit(N, k);
  end
  assign cry_v[0] = '0;

  for (genvar j = 0; j < N; j++) begin : g_row
    bwm_pp_row #(.N(N), .ROW(j)) u_pp (
      .mcand      (a_in),
      .mplier_bit (b_in[j]),
      .pp_vec     (pp_v[j])
    );
    bwm_csa_row #(.W(W)) u_csa (
      .sum_in  (sum_v[j]),
      .cry_in  (cry_v[j]),
      .pp_in   (pp_v[j]),
      .sum_out (sum_v[j+1]),
      .cry_out (cry_v[j+1])
    );

    // R5: each row conserves the carry-save total plus its partial product.
    assert_row_keeps_sum_R5: assert property (@(posedge clk) disable iff (rst)
      (sum_v[j+1] + cry_v[j+1]) == (sum_v[j] + cry_v[j] + pp_v[j]));
  end

  bwm_cpa #(.W(W)) u_cpa (
    .op_x  (sum_v[N]),
    .op_y  (cry_v[N]),
    .total (prod_c)
  );

  if (OUT_REG) begin : g_reg
    logic signed [W-1:0] prod_q;
    logic signed [W-1:0] ref_prod;
    assign ref_prod = a_in * b_in;

    always_ff @(posedge clk) begin
      if (rst) prod_q <= '0;
      else     prod_q <= prod_c;
    end
    assign prod_out = prod_q;

    assert_product_R1: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> prod_out == $past(ref_prod));
    assert_reset_clears_R2: assert property (@(posedge clk)
      rst |=> prod_out == '0);
    assert_min_sq_R3: assert property (@(posedge clk) disable iff (rst)
      (a_in == {1'b1, {(N-1){1'b0}}} && b_in == {1'b1, {(N-1){1'b0}}})
      |=> prod_out == (W'(1) << (W - 2)));
    assert_min_neg1_R4: assert property (@(posedge clk) disable iff (rst)
      (a_in == {1'b1, {(N-1){1'b0}}} && b_in == '1)
      |=> prod_out == (W'(1) << (N - 1)));
    assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (a_in == '0 || b_in == '0) |=> prod_out == '0);
  end else begin : g_comb
    assign prod_out = prod_c;
  end
endmodule

// File: tb/bw_csa_mult_bench.sv
module bw_csa_mult_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [15:0] a16 = '0, b16 = '0;
  logic signed [31:0] p16;
  logic signed [3:0]  a4 = '0, b4 = '0;
  logic signed [7:0]  p4;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bw_csa_mult #(.N(16), .OUT_REG(1'b1)) u_bw_csa_mult (
    .clk(clk), .rst(rst), .a_in(a16), .b_in(b16), .prod_out(p16));
  bw_csa_mult #(.N(4), .OUT_REG(1'b1)) u_bw_csa_mult_n4 (
    .clk(clk), .rst(rst), .a_in(a4), .b_in(b4), .prod_out(p4));

  // {a, b, expected product}
  localparam logic [63:0] VEC [0:7] = '{
    {16'h8000, 16'h8000, 32'h4000_0000},  // R3
    {16'h8000, 16'hFFFF, 32'h0000_8000},  // R4
    {16'hFFFF, 16'h8000, 32'h0000_8000},  // R4
    {16'h7FFF, 16'h7FFF, 32'h3FFF_0001},  // R1
    {16'h7FFF, 16'h8000, 32'hC000_8000},  // R7
    {16'h0000, 16'h8000, 32'h0000_0000},  // R6
    {16'hFFFF, 16'hFFFF, 32'h0000_0001},  // R7
    {16'h0003, 16'hFFFB, 32'hFFFF_FFF1}   // R7
  };
  localparam string VTAG [0:7] = '{"R3", "R4", "R4", "R1", "R7", "R6", "R7", "R7"};

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R2: reset state with live operands.
    a16 = 16'h7FFF; b16 = 16'h7FFF; a4 = 4'sd7; b4 = 4'sd7;
    repeat (2) @(negedge clk);
    check("R2", longint'(p16), 0);
    check("R2", longint'(p4), 0);
    rst = 1'b0;

    // Directed table on the 16-bit instance.
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      a16 = VEC[v][63:48];
      b16 = VEC[v][47:32];
      @(negedge clk);
      check(VTAG[v], longint'(p16), longint'($signed(VEC[v][31:0])));
    end

    // R1, R3, R4, R6, R7: every operand pair of the 4-bit instance.
    for (int x = -8; x < 8; x++) begin
      for (int y = -8; y < 8; y++) begin
        @(negedge clk);
        a4 = 4'(x);
        b4 = 4'(y);
        @(negedge clk);
        check("R1", longint'(p4), longint'(x * y));
      end
    end
    @(negedge clk); a4 = -4'sd8; b4 = -4'sd8;
    @(negedge clk); check("R3", longint'(p4), 64);
    @(negedge clk); a4 = -4'sd8; b4 = -4'sd1;
    @(negedge clk); check("R4", longint'(p4), 8);

    // R1/R7: random 16-bit operands.
    for (int r = 0; r < 3000; r++) begin
      @(negedge clk);
      a16 = 16'($urandom);
      b16 = 16'($urandom);
      @(negedge clk);
      check("R1", longint'(p16), longint'(a16) * longint'(b16));
    end

    // R2: reset mid-run overrides a nonzero product.
    @(negedge clk); a16 = 16'h8000; b16 = 16'h8000; rst = 1'b1;
    @(negedge clk); check("R2", longint'(p16), 0);
    rst = 1'b0;
    @(negedge clk); check("R3", longint'(p16), 64'h4000_0000);

    finish_run();
  end
endmodule